// File: doc/BRIEF.md
# Constructive AND-NOT Event Node

This block is one gate of a network that spreads logical facts as events. It computes `C = A AND NOT B` from two input event channels and sends the result as one output event. Each input event is a one-cycle valid pulse with a data bit. The event lands in a one-place slot inside the node. When the node consumes the event, it returns a one-cycle free pulse to the sender, and the sender uses that pulse as its credit for the next event. Back-pressure on the inputs therefore works by credit. A sender keeps at most one event outstanding per channel. If an event arrives while the slot is still occupied, the node discards it and leaves the stored event as it was.

The node consumes input A first and input B second, once per logical tick. If A is 0, the result is already known to be false, so the node may emit C before B arrives. Otherwise the result is decided when B is consumed. Each partial result is ANDed into one held value, so C is emitted only once per tick. The output waits on the downstream free level (`c_free`), which acts as the ready signal. C is sent as a one-cycle `c_vld` pulse only in a cycle where `c_free` is high.

Once both inputs have been consumed and C has been sent, the node clears itself for the next tick without any outside reset. An event that belongs to the next tick can arrive early and waits in its slot. Three level outputs tell a scheduler which event the node is currently blocked on.

Top module: `anot_node`

## Requirements
- R1: After reset, `a_wait` is 1, `b_wait` and `c_free_wait` are 0, and no free or `c_vld` pulse occurs.
- R2: A B event that arrives before the A event of its tick is held and not consumed: `b_free` stays 0 until A has been consumed.
- R3: Each consumed input produces exactly one one-cycle free pulse on its own channel (`a_free` for A, `b_free` for B) per tick.
- R4: The data bit sent with `c_vld` equals `A & ~B` for all four input combinations.
- R5: When A is 0 and `c_free` is high, C (data 0) is emitted before any B event has arrived.
- R6: C is emitted exactly once per tick, and `c_vld` is never high while `c_free` is low.
- R7: `c_free_wait` is 1 while the result is decided, C has not been sent and `c_free` is low.
- R8: `a_wait` is 1 while the node awaits A and its slot is empty. `b_wait` is 1 while the node awaits B and its slot is empty.
- R9: An input event that arrives while its slot is occupied is discarded, and the stored value is used unchanged.
- R10: After both inputs have been consumed and C has been sent, the node returns to awaiting A (`a_wait` 1, `c_free_wait` 0) with no external action.
- R11: An A event for the next tick that arrives while B is still awaited stays in its slot. It is consumed after the current tick closes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_vld | input | 1 | A event pulse |
| a_dat | input | 1 | A data bit |
| a_free | output | 1 | A slot consumed (credit return) |
| a_wait | output | 1 | Blocked on an A event |
| b_vld | input | 1 | B event pulse |
| b_dat | input | 1 | B data bit |
| b_free | output | 1 | B slot consumed (credit return) |
| b_wait | output | 1 | Blocked on a B event |
| c_vld | output | 1 | C event pulse |
| c_dat | output | 1 | C data bit |
| c_free | input | 1 | Downstream ready level |
| c_free_wait | output | 1 | Result decided, blocked on `c_free` |

## Verification
Consumption of B and emission of C can fall in the same cycle. This happens on the early path, where A is 0 and the output stage is already waiting while the B event is being taken. The bench provokes it by sending A=0 with `c_free` held high, then placing B in its slot so that it is consumed in the very cycle the output stage fires. It judges the result by seeing `b_free` and `c_vld` high together, with exactly one C of data 0 and one credit per channel for the tick.

// File: rtl/anot_pkg.sv
package anot_pkg;
  localparam int NUM_IN = 2;
  localparam int IDX_A  = 0;
  localparam int IDX_B  = 1;

  typedef enum logic [1:0] {
    IN_AWAIT_A = 2'd0,
    IN_AWAIT_B = 2'd1,
    IN_DONE    = 2'd2
  } in_state_e;

  typedef enum logic [1:0] {
    OUT_IDLE = 2'd0,
    OUT_WAIT = 2'd1,
    OUT_DONE = 2'd2
  } out_state_e;
endpackage

// File: rtl/anot_slot.sv
module anot_slot #(
  parameter int DW = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_vld,
  input  logic [DW-1:0] wr_dat,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] dat
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      dat  <= '0;
    end else if (wr_vld && !full) begin
      full <= 1'b1;
      dat  <= wr_dat;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // an occupied slot keeps its value until taken (R9)
  p_hold_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(dat)));
endmodule

// File: rtl/anot_in_seq.sv
module anot_in_seq
  import anot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_full,
  input  logic a_bit,
  input  logic b_full,
  input  logic b_bit,
  input  logic tick_end,
  output logic a_take,
  output logic b_take,
  output logic known,
  output logic aux,
  output logic in_done,
  output logic a_wait,
  output logic b_wait
);
  in_state_e st;

  assign a_take  = (st == IN_AWAIT_A) && a_full;
  assign b_take  = (st == IN_AWAIT_B) && b_full;
  assign a_wait  = (st == IN_AWAIT_A) && !a_full;
  assign b_wait  = (st == IN_AWAIT_B) && !b_full;
  assign in_done = (st == IN_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IN_AWAIT_A;
      aux   <= 1'b1;
      known <= 1'b0;
    end else if (tick_end) begin
      st    <= IN_AWAIT_A;
      aux   <= 1'b1;
      known <= 1'b0;
    end else if (a_take) begin
      st <= IN_AWAIT_B;
      if (!a_bit) begin
        aux   <= 1'b0;
        known <= 1'b1;
      end
    end else if (b_take) begin
      st    <= IN_DONE;
      known <= 1'b1;
      aux   <= aux & ~b_bit;
    end
  end

  // credit pulses last one cycle (R3)
  p_free_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    a_take |=> !a_take);
  // A is never taken right after B in the same tick (R2)
  p_no_a_after_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    b_take |=> !a_take);
endmodule

// File: rtl/anot_out_seq.sv
module anot_out_seq
  import anot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic known,
  input  logic c_free,
  input  logic tick_end,
  output logic c_fire,
  output logic c_free_wait,
  output logic out_done
);
  out_state_e st;

  assign c_fire      = (st == OUT_WAIT) && c_free;
  assign c_free_wait = (st == OUT_WAIT) && !c_free;
  assign out_done    = (st == OUT_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= OUT_IDLE;
    end else if (tick_end) begin
      st <= OUT_IDLE;
    end else begin
      case (st)
        OUT_IDLE: if (known)  st <= OUT_WAIT;
        OUT_WAIT: if (c_free) st <= OUT_DONE;
        default:  st <= st;
      endcase
    end
  end

  // emission only once the input side has decided the result (R5)
  p_emit_after_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c_fire |-> known);
  // a single emission per tick (R6)
  p_single_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_fire |=> !c_fire);
endmodule

// File: rtl/anot_node.sv
module anot_node
  import anot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic a_vld,
  input  logic a_dat,
  output logic a_free,
  output logic a_wait,
  input  logic b_vld,
  input  logic b_dat,
  output logic b_free,
  output logic b_wait,
  output logic c_vld,
  output logic c_dat,
  input  logic c_free,
  output logic c_free_wait
);
  localparam int DW = 1;

  logic [NUM_IN-1:0] s_vld, s_full, s_take;
  logic [DW-1:0]     s_wdat [NUM_IN];
  logic [DW-1:0]     s_dat  [NUM_IN];
  logic known, aux, in_done, out_done, tick_end, c_fire;

  assign s_vld[IDX_A]  = a_vld;
  assign s_vld[IDX_B]  = b_vld;
  assign s_wdat[IDX_A] = a_dat;
  assign s_wdat[IDX_B] = b_dat;

  generate
    for (genvar i = 0; i < NUM_IN; i++) begin : g_slot
      anot_slot #(.DW(DW)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(s_vld[i]), .wr_dat(s_wdat[i]),
        .take(s_take[i]), .full(s_full[i]), .dat(s_dat[i])
      );
    end
  endgenerate

  assign tick_end = in_done && out_done;

  anot_in_seq u_in (
    .clk(clk), .rst_n(rst_n),
    .a_full(s_full[IDX_A]), .a_bit(s_dat[IDX_A][0]),
    .b_full(s_full[IDX_B]), .b_bit(s_dat[IDX_B][0]),
    .tick_end(tick_end),
    .a_take(s_take[IDX_A]), .b_take(s_take[IDX_B]),
    .known(known), .aux(aux), .in_done(in_done),
    .a_wait(a_wait), .b_wait(b_wait)
  );

  anot_out_seq u_out (
    .clk(clk), .rst_n(rst_n),
    .known(known), .c_free(c_free), .tick_end(tick_end),
    .c_fire(c_fire), .c_free_wait(c_free_wait), .out_done(out_done)
  );

  assign a_free = s_take[IDX_A];
  assign b_free = s_take[IDX_B];
  assign c_vld  = c_fire;
  assign c_dat  = c_fire & aux;

  // no emission without the downstream ready level (R6)
  p_c_needs_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |-> c_free);
  // the tick closes only after both credits and the emission (R10)
  p_tick_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick_end |=> (!c_vld && !b_free));
endmodule

// File: tb/sim_anot_node.sv
module sim_anot_node;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_vld = 0, a_dat = 0, b_vld = 0, b_dat = 0, c_free = 0;
  logic a_free, a_wait, b_free, b_wait, c_vld, c_dat, c_free_wait;

  int n_chk = 0, n_fail = 0;
  int cnt_af = 0, cnt_bf = 0, cnt_c = 0, cnt_bad = 0;
  logic c_last = 0, coincide = 0, early_seen = 0;

  always #10 clk = ~clk;

  anot_node u0 (
    .clk(clk), .rst_n(rst_n),
    .a_vld(a_vld), .a_dat(a_dat), .a_free(a_free), .a_wait(a_wait),
    .b_vld(b_vld), .b_dat(b_dat), .b_free(b_free), .b_wait(b_wait),
    .c_vld(c_vld), .c_dat(c_dat), .c_free(c_free), .c_free_wait(c_free_wait)
  );

  always @(negedge clk) begin
    #2;
    if (a_free) cnt_af++;
    if (b_free) cnt_bf++;
    if (c_vld) begin
      cnt_c++;
      c_last = c_dat;
      if (!c_free) cnt_bad++;
    end
    if (b_free && c_vld) coincide = 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #3;
    end
  endtask

  task automatic clr();
    cnt_af = 0; cnt_bf = 0; cnt_c = 0; coincide = 0;
  endtask

  task automatic send_a(input logic v);
    @(negedge clk); a_vld = 1; a_dat = v;
    @(negedge clk); a_vld = 0; #3;
  endtask

  task automatic send_b(input logic v);
    @(negedge clk); b_vld = 1; b_dat = v;
    @(negedge clk); b_vld = 0; #3;
  endtask

  task automatic run_tick(input logic av, input logic bv, input int order, input int late);
    logic exp;
    exp = av & ~bv;
    clr();
    check(a_wait == 1, "R8 a_wait idle", a_wait, 1);
    if (late == 0) c_free = 1;
    if (order == 0) begin
      send_a(av);
      cyc(4);
      check(cnt_af == 1 && b_wait == 1, "R8 b_wait after A", b_wait, 1);
      if (av == 0 && late == 0)
        check(cnt_c == 1 && c_last == 0 && cnt_bf == 0, "R5 early emit", cnt_c, 1);
      send_b(bv);
    end else begin
      send_b(bv);
      cyc(4);
      check(cnt_bf == 0 && a_wait == 1, "R2 B held", cnt_bf, 0);
      send_a(av);
    end
    cyc(6);
    if (late != 0) begin
      check(cnt_c == 0, "R6 no emit without c_free", cnt_c, 0);
      check(c_free_wait == 1, "R7 c_free_wait", c_free_wait, 1);
      @(negedge clk); c_free = 1;
      cyc(4);
    end
    check(cnt_c == 1, "R6 one emission", cnt_c, 1);
    check(c_last == exp, "R4 result", c_last, exp);
    check(cnt_af == 1 && cnt_bf == 1, "R3 credits", cnt_af * 10 + cnt_bf, 11);
    @(negedge clk); c_free = 0;
    cyc(3);
    check(a_wait == 1 && c_free_wait == 0 && b_wait == 0, "R10 tick reset", a_wait, 1);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(3);
    // R1 reset state
    check(a_wait == 1 && b_wait == 0 && c_free_wait == 0, "R1 waits", a_wait, 1);
    check(cnt_af == 0 && cnt_bf == 0 && cnt_c == 0, "R1 no pulses", cnt_c, 0);

    for (int a = 0; a < 2; a++)
      for (int b = 0; b < 2; b++)
        for (int o = 0; o < 2; o++)
          for (int l = 0; l < 2; l++)
            run_tick(a[0], b[0], o, l);

    // same-cycle B consumption and C emission
    clr();
    c_free = 1;
    @(negedge clk); a_vld = 1; a_dat = 0;
    @(negedge clk); a_vld = 0;
    @(negedge clk); b_vld = 1; b_dat = 1;
    @(negedge clk); b_vld = 0; #3;
    cyc(6);
    check(coincide == 1, "R5 b_free with c_vld", coincide, 1);
    check(cnt_c == 1 && c_last == 0, "R4 coincident result", c_last, 0);
    @(negedge clk); c_free = 0;
    cyc(3);

    // R11 early next-tick A, R9 discard on full slot
    clr();
    send_a(1);
    cyc(3);
    send_a(1);
    cyc(2);
    send_a(0);
    cyc(3);
    check(cnt_af == 1 && b_wait == 1, "R11 next A held", cnt_af, 1);
    send_b(0);
    @(negedge clk); c_free = 1;
    cyc(6);
    check(cnt_c == 1 && c_last == 1, "R4 first tick", c_last, 1);
    cyc(3);
    check(cnt_af == 2, "R11 held A consumed", cnt_af, 2);
    send_b(0);
    cyc(6);
    check(cnt_c == 2 && c_last == 1, "R9 stored A used", c_last, 1);
    check(cnt_bad == 0, "R6 c_vld only with c_free", cnt_bad, 0);
    @(negedge clk); c_free = 0;
    cyc(3);
    check(a_wait == 1, "R10 final idle", a_wait, 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule